// File: doc/BRIEF.md
# Stereo Matrix with Quality-Driven Mono Blend

This block turns a decoded sum channel (left plus right) and difference channel (left minus right) into left and right audio samples. Both channels arrive as signed fixed-point words with a shared valid strobe. An unsigned reception-quality metric comes with each sample. The difference channel is weighted by a blend factor before the matrix, so reception can fade smoothly between full stereo and mono.

The blend factor moves by at most one step per accepted sample toward a target. Quality below a low threshold pulls the target to mono. Quality above a high threshold pulls it to full stereo. Between the two thresholds the factor holds where it is. A force-mono input overrides the quality path. A status output reports whether stereo is in effect.

Each channel then passes through an optional first-order de-emphasis low-pass. It has two selectable time constants, 50 µs and 75 µs, with coefficients fixed for one sample rate (48 kHz by default). The filter can be switched off at run time. A parameter can also leave it out of the build.

Top module: `stereo_blend_matrix`

## Requirements
- R1: Each accepted sample uses blend factor b, the value after this sample's ramp step, as an 8-bit unsigned value. The scaled difference is floor(diff*b/256). Left is sum plus that term and right is sum minus it.
- R2: When b is 0, both outputs equal the sum channel (mono).
- R3: b changes by at most 1 between consecutive accepted samples, except when force-mono clears it.
- R4: If quality < thr_lo, b steps down by 1, stopping at 0. If quality > thr_hi, b steps up by 1, stopping at 255. If thr_lo <= quality <= thr_hi, b holds.
- R5: b changes only in cycles where in_valid is high.
- R6: A sample accepted with force_mono high is output as mono, and it sets b to 0. After force_mono is released, the ramp starts again from 0. While force_mono is high, stereo is low.
- R7: stereo is high exactly when b is nonzero and force_mono is low.
- R8: Each output is clamped to the signed SAMPLE_W range, which is -32768 to 32767 by default.
- R9: out_valid pulses high for one cycle, two clock cycles after the in_valid cycle it belongs to.
- R10: With deemph_en high, each channel state updates as y += floor(k*(x-y)/32768). k is 11167 when tc_sel = 0 (50 µs) and 7946 when tc_sel = 1 (75 µs). With deemph_en low, y follows the matrix output directly.
- R11: After reset, out_valid, out_left, out_right, stereo and b are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_sum | input | SAMPLE_W | Signed sum channel |
| in_diff | input | SAMPLE_W | Signed difference channel |
| quality | input | QUAL_W | Unsigned reception quality |
| thr_lo | input | QUAL_W | Quality below this ramps toward mono |
| thr_hi | input | QUAL_W | Quality above this ramps toward stereo |
| force_mono | input | 1 | Override to mono |
| deemph_en | input | 1 | Enable the de-emphasis filter |
| tc_sel | input | 1 | 0 selects 50 µs, 1 selects 75 µs |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | SAMPLE_W | Signed left sample |
| out_right | output | SAMPLE_W | Signed right sample |
| stereo | output | 1 | Stereo in effect |

## Verification
The assertions check on every cycle the properties that depend only on control flow. These are the one-step limit on the blend factor, its stability between strobes, clearing under force-mono, the agreement of the status flag with the factor, and the fixed two-cycle output strobe. Arithmetic correctness cannot be shown that way: the scaled matrix, clamping at both rails, the exact ramp sequence across the threshold bands, and the filter recurrence for each time constant. The bench's scenarios show these by comparing every output sample with a model computed from the requirements.

// File: rtl/stmx_pkg.sv
package stmx_pkg;
   typedef enum logic {
      TC_SHORT = 1'b0,
      TC_LONG  = 1'b1
   } stmx_tc_e;

   typedef enum logic [1:0] {
      RAMP_DOWN = 2'd0,
      RAMP_HOLD = 2'd1,
      RAMP_UP   = 2'd2
   } stmx_ramp_e;
endpackage

// File: rtl/stmx_blend_ramp.sv
module stmx_blend_ramp
   import stmx_pkg::*;
#(
   parameter int QUAL_W  = 8,
   parameter int BLEND_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               step_en,
   input  logic               force_mono,
   input  logic [QUAL_W-1:0]  quality,
   input  logic [QUAL_W-1:0]  thr_lo,
   input  logic [QUAL_W-1:0]  thr_hi,
   output logic [BLEND_W-1:0] blend_next,
   output logic [BLEND_W-1:0] blend_q
);
   localparam logic [BLEND_W-1:0] BLEND_MAX = '1;
   localparam logic [BLEND_W-1:0] BLEND_ONE = BLEND_W'(1);

   stmx_ramp_e dir;

   always_comb begin
      if (quality < thr_lo) begin
         dir = (blend_q != '0) ? RAMP_DOWN : RAMP_HOLD;
      end else if (quality > thr_hi) begin
         dir = (blend_q != BLEND_MAX) ? RAMP_UP : RAMP_HOLD;
      end else begin
         dir = RAMP_HOLD;
      end
   end

   always_comb begin
      if (force_mono) begin
         blend_next = '0;
      end else begin
         case (dir)
            RAMP_DOWN: blend_next = blend_q - BLEND_ONE;
            RAMP_UP:   blend_next = blend_q + BLEND_ONE;
            default:   blend_next = blend_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blend_q <= '0;
      end else if (step_en) begin
         blend_q <= blend_next;
      end
   end
endmodule

// File: rtl/stmx_matrix.sv
module stmx_matrix #(
   parameter int SAMPLE_W = 16,
   parameter int BLEND_W  = 8
) (
   input  logic signed [SAMPLE_W-1:0] sum_in,
   input  logic signed [SAMPLE_W-1:0] diff_in,
   input  logic        [BLEND_W-1:0]  blend,
   output logic signed [SAMPLE_W-1:0] chan_out [2]
);
   localparam int PROD_W = SAMPLE_W + BLEND_W + 1;
   localparam int MIX_W  = SAMPLE_W + 2;
   localparam logic signed [MIX_W-1:0] POS_RAIL = MIX_W'((2 ** (SAMPLE_W - 1)) - 1);
   localparam logic signed [MIX_W-1:0] NEG_RAIL = -MIX_W'(2 ** (SAMPLE_W - 1));

   logic signed [PROD_W-1:0]   prod;
   logic signed [SAMPLE_W:0]   scaled;

   always_comb begin
      prod   = diff_in * $signed({1'b0, blend});
      scaled = (SAMPLE_W + 1)'(prod >>> BLEND_W);
   end

   function automatic logic signed [SAMPLE_W-1:0] clamp(input logic signed [MIX_W-1:0] v);
      if (v > POS_RAIL) begin
         return POS_RAIL[SAMPLE_W-1:0];
      end else if (v < NEG_RAIL) begin
         return NEG_RAIL[SAMPLE_W-1:0];
      end else begin
         return v[SAMPLE_W-1:0];
      end
   endfunction

   for (genvar ch = 0; ch < 2; ch++) begin : g_chan
      logic signed [MIX_W-1:0] mix;
      if (ch == 0) begin : g_add
         assign mix = MIX_W'(sum_in) + MIX_W'(scaled);
      end else begin : g_sub
         assign mix = MIX_W'(sum_in) - MIX_W'(scaled);
      end
      assign chan_out[ch] = clamp(mix);
   end
endmodule

// File: rtl/stmx_deemph.sv
module stmx_deemph
   import stmx_pkg::*;
#(
   parameter int                SAMPLE_W   = 16,
   parameter int                COEF_W     = 16,
   parameter logic [COEF_W-1:0] COEF_SHORT = COEF_W'(11167),
   parameter logic [COEF_W-1:0] COEF_LONG  = COEF_W'(7946),
   parameter bit                PRESENT    = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       smp_en,
   input  logic                       filt_en,
   input  logic                       tc_sel,
   input  logic signed [SAMPLE_W-1:0] x_in,
   output logic signed [SAMPLE_W-1:0] y_out
);
   localparam int FRAC   = COEF_W - 1;
   localparam int DIFF_W = SAMPLE_W + 1;
   localparam int PROD_W = DIFF_W + COEF_W + 1;
   localparam int STEP_W = SAMPLE_W + 3;
   localparam logic [COEF_W-1:0] COEF_TAB [2] = '{COEF_SHORT, COEF_LONG};

   logic signed [SAMPLE_W-1:0] y_q;
   logic signed [SAMPLE_W-1:0] y_next;

   if (PRESENT) begin : g_filter
      stmx_tc_e                 tc;
      logic [COEF_W-1:0]        alpha;
      logic signed [DIFF_W-1:0] delta;
      logic signed [PROD_W-1:0] prod;
      logic signed [STEP_W-1:0] step;
      logic signed [STEP_W-1:0] acc;

      always_comb begin
         tc    = stmx_tc_e'(tc_sel);
         alpha = COEF_TAB[(tc == TC_LONG) ? 1 : 0];
         delta = DIFF_W'(x_in) - DIFF_W'(y_q);
         prod  = delta * $signed({1'b0, alpha});
         step  = STEP_W'(prod >>> FRAC);
         acc   = STEP_W'(y_q) + step;
         y_next = filt_en ? SAMPLE_W'(acc) : x_in;
      end
   end else begin : g_bypass
      assign y_next = x_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         y_q <= '0;
      end else if (smp_en) begin
         y_q <= y_next;
      end
   end

   assign y_out = y_q;
endmodule

// File: rtl/stereo_blend_matrix.sv
module stereo_blend_matrix
   import stmx_pkg::*;
#(
   parameter int                SAMPLE_W   = 16,
   parameter int                QUAL_W     = 8,
   parameter int                BLEND_W    = 8,
   parameter int                COEF_W     = 16,
   parameter logic [COEF_W-1:0] COEF_50US  = COEF_W'(11167),
   parameter logic [COEF_W-1:0] COEF_75US  = COEF_W'(7946),
   parameter bit                HAS_DEEMPH = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic signed [SAMPLE_W-1:0] in_sum,
   input  logic signed [SAMPLE_W-1:0] in_diff,
   input  logic        [QUAL_W-1:0]   quality,
   input  logic        [QUAL_W-1:0]   thr_lo,
   input  logic        [QUAL_W-1:0]   thr_hi,
   input  logic                       force_mono,
   input  logic                       deemph_en,
   input  logic                       tc_sel,
   output logic                       out_valid,
   output logic signed [SAMPLE_W-1:0] out_left,
   output logic signed [SAMPLE_W-1:0] out_right,
   output logic                       stereo
);
   localparam int NUM_CH = 2;
   localparam longint COEF_LIMIT = longint'(1) << (COEF_W - 1);

   if (SAMPLE_W < 4 || SAMPLE_W > 32) begin : g_bad_sample_w
      $error("SAMPLE_W must lie in 4..32");
   end
   if (BLEND_W < 1 || BLEND_W > 12) begin : g_bad_blend_w
      $error("BLEND_W must lie in 1..12");
   end
   if (QUAL_W < 1) begin : g_bad_qual_w
      $error("QUAL_W must be positive");
   end
   if (longint'(COEF_50US) >= COEF_LIMIT || longint'(COEF_75US) >= COEF_LIMIT) begin : g_bad_coef
      $error("filter coefficients must stay below one");
   end

   logic [BLEND_W-1:0]         blend_next;
   logic [BLEND_W-1:0]         blend_q;
   logic signed [SAMPLE_W-1:0] mat_comb [NUM_CH];
   logic signed [SAMPLE_W-1:0] mat_q    [NUM_CH];
   logic signed [SAMPLE_W-1:0] filt_out [NUM_CH];
   logic                       stage1_v;
   logic                       stage2_v;

   stmx_blend_ramp #(
      .QUAL_W  (QUAL_W),
      .BLEND_W (BLEND_W)
   ) i_ramp (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_en    (in_valid),
      .force_mono (force_mono),
      .quality    (quality),
      .thr_lo     (thr_lo),
      .thr_hi     (thr_hi),
      .blend_next (blend_next),
      .blend_q    (blend_q)
   );

   stmx_matrix #(
      .SAMPLE_W (SAMPLE_W),
      .BLEND_W  (BLEND_W)
   ) i_matrix (
      .sum_in   (in_sum),
      .diff_in  (in_diff),
      .blend    (blend_next),
      .chan_out (mat_comb)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage1_v <= 1'b0;
         stage2_v <= 1'b0;
      end else begin
         stage1_v <= in_valid;
         stage2_v <= stage1_v;
      end
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mat_q[ch] <= '0;
         end else if (in_valid) begin
            mat_q[ch] <= mat_comb[ch];
         end
      end

      stmx_deemph #(
         .SAMPLE_W   (SAMPLE_W),
         .COEF_W     (COEF_W),
         .COEF_SHORT (COEF_50US),
         .COEF_LONG  (COEF_75US),
         .PRESENT    (HAS_DEEMPH)
      ) i_deemph (
         .clk     (clk),
         .rst_n   (rst_n),
         .smp_en  (stage1_v),
         .filt_en (deemph_en),
         .tc_sel  (tc_sel),
         .x_in    (mat_q[ch]),
         .y_out   (filt_out[ch])
      );
   end

   assign out_valid = stage2_v;
   assign out_left  = filt_out[0];
   assign out_right = filt_out[1];
   assign stereo    = (blend_q != '0) && !force_mono;
endmodule

// File: rtl/stmx_chk.sv
module stmx_chk #(
   parameter int BLEND_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               force_mono,
   input logic [BLEND_W-1:0] blend,
   input logic               stereo,
   input logic               out_valid
);
   // R3: one step at most per accepted sample unless force-mono cleared it
   assert_blend_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !($past(in_valid) && $past(force_mono)) |->
         ((int'(blend) - int'($past(blend)) <= 1) && (int'(blend) - int'($past(blend)) >= -1)));

   // R5: factor frozen between strobes
   assert_blend_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> $stable(blend));

   // R6: forced sample leaves the factor at zero
   assert_force_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid) && $past(force_mono)) |-> (blend == '0));

   // R6: status low under force
   assert_force_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
      force_mono |-> !stereo);

   // R7: stereo flag implies nonzero factor
   assert_status_blend_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stereo |-> (blend != '0));

   // R7: nonzero factor without force implies stereo flag
   assert_blend_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((blend != '0) && !force_mono) |-> stereo);

   // R9: output strobe two cycles after input strobe
   assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid, 2));
endmodule

bind stereo_blend_matrix stmx_chk #(
   .BLEND_W (BLEND_W)
) i_stmx_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .force_mono (force_mono),
   .blend      (blend_q),
   .stereo     (stereo),
   .out_valid  (out_valid)
);

// File: tb/test_stereo_blend_matrix.sv
module test_stereo_blend_matrix;
   localparam int LO_T = 50;
   localparam int HI_T = 200;
   localparam int Q_HI = 230;
   localparam int Q_MID = 120;
   localparam int Q_LO = 10;
   localparam int K50 = 11167;
   localparam int K75 = 7946;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic signed [15:0] in_sum = '0;
   logic signed [15:0] in_diff = '0;
   logic        [7:0]  quality = '0;
   logic        [7:0]  thr_lo = 8'(LO_T);
   logic        [7:0]  thr_hi = 8'(HI_T);
   logic              force_mono = 1'b0;
   logic              deemph_en = 1'b0;
   logic              tc_sel = 1'b0;
   logic              out_valid;
   logic signed [15:0] out_left;
   logic signed [15:0] out_right;
   logic              stereo;

   int checks = 0;
   int errors = 0;
   int bl = 0;
   int yl = 0;
   int yr = 0;

   always #5 clk = ~clk;

   stereo_blend_matrix i_stereo_blend_matrix (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_sum     (in_sum),
      .in_diff    (in_diff),
      .quality    (quality),
      .thr_lo     (thr_lo),
      .thr_hi     (thr_hi),
      .force_mono (force_mono),
      .deemph_en  (deemph_en),
      .tc_sel     (tc_sel),
      .out_valid  (out_valid),
      .out_left   (out_left),
      .out_right  (out_right),
      .stereo     (stereo)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int clamp16(input int v);
      if (v > 32767) return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   // Drives one sample and checks its output against the requirement model.
   task automatic send(input int s, input int d, input int q, input string tag);
      int scl;
      int el;
      int er;
      int k;
      @(negedge clk);
      in_sum = 16'(s);
      in_diff = 16'(d);
      quality = 8'(q);
      in_valid = 1'b1;
      if (force_mono) bl = 0;
      else if (q < LO_T) bl = (bl > 0) ? bl - 1 : 0;
      else if (q > HI_T) bl = (bl < 255) ? bl + 1 : 255;
      scl = (d * bl) >>> 8;
      el = clamp16(s + scl);
      er = clamp16(s - scl);
      k = tc_sel ? K75 : K50;
      if (deemph_en) begin
         yl = yl + ((k * (el - yl)) >>> 15);
         yr = yr + ((k * (er - yr)) >>> 15);
      end else begin
         yl = el;
         yr = er;
      end
      @(negedge clk);
      in_valid = 1'b0;
      chk("R9 no early strobe", int'(out_valid), 0);
      @(negedge clk);
      chk("R9 strobe", int'(out_valid), 1);
      chk({tag, " left"}, int'(out_left), yl);
      chk({tag, " right"}, int'(out_right), yr);
      chk(force_mono ? "R6 status" : "R7 status", int'(stereo), (bl != 0 && !force_mono) ? 1 : 0);
      @(negedge clk);
      chk("R9 one-cycle strobe", int'(out_valid), 0);
   endtask

   task automatic t_reset;
      repeat (4) @(negedge clk);
      chk("R11 valid", int'(out_valid), 0);
      chk("R11 left", int'(out_left), 0);
      chk("R11 right", int'(out_right), 0);
      chk("R11 stereo", int'(stereo), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 valid after release", int'(out_valid), 0);
   endtask

   task automatic t_mono_start;
      send(1000, 500, Q_MID, "R2 mono at zero blend");
      chk("R2 equal channels", int'(out_left), int'(out_right));
   endtask

   task automatic t_ramp_up;
      for (int i = 1; i <= 5; i++) begin
         send(0, 256, Q_HI, "R4 ramp up");
         chk("R3 unit step", int'(out_left), i);
      end
   endtask

   task automatic t_hold_band;
      send(0, 256, LO_T, "R4 hold at low threshold");
      send(0, 256, HI_T, "R4 hold at high threshold");
      send(0, 256, Q_MID, "R4 hold mid");
      chk("R4 held value", int'(out_left), 5);
   endtask

   task automatic t_idle;
      quality = 8'(Q_HI);
      in_diff = 16'sd256;
      repeat (20) @(negedge clk);
      send(0, 256, Q_MID, "R5 idle cycles");
      chk("R5 unchanged", int'(out_left), 5);
   endtask

   task automatic t_ramp_down;
      send(0, 256, Q_LO, "R4 ramp down");
      send(0, 256, Q_LO, "R4 ramp down");
      chk("R4 down two", int'(out_left), 3);
   endtask

   task automatic t_full_ramp;
      for (int i = 0; i < 260; i++) begin
         send(0, 256, Q_HI, "R3 full ramp");
      end
      chk("R4 top stop", int'(out_left), 255);
      send(1000, -3000, Q_MID, "R1 matrix negative diff");
      chk("R1 left value", int'(out_left), 1000 - 2989);
      send(-1200, 700, Q_MID, "R1 matrix negative sum");
   endtask

   task automatic t_saturation;
      send(30000, 10000, Q_MID, "R8 positive rail");
      chk("R8 left clamp", int'(out_left), 32767);
      send(-30000, 10000, Q_MID, "R8 negative rail");
      chk("R8 right clamp", int'(out_right), -32768);
   endtask

   task automatic t_force;
      force_mono = 1'b1;
      @(negedge clk);
      chk("R6 status drops", int'(stereo), 0);
      send(500, 1000, Q_HI, "R6 forced mono");
      chk("R6 mono out", int'(out_left), 500);
      force_mono = 1'b0;
      send(0, 256, Q_HI, "R6 restart ramp");
      chk("R6 from zero", int'(out_left), 1);
      force_mono = 1'b1;
      send(0, 256, Q_HI, "R6 forced again");
   endtask

   task automatic t_deemph;
      deemph_en = 1'b1;
      tc_sel = 1'b0;
      for (int i = 0; i < 4; i++) send(10000, 300, Q_HI, "R10 50us");
      tc_sel = 1'b1;
      for (int i = 0; i < 4; i++) send(-8000, 300, Q_HI, "R10 75us");
      deemph_en = 1'b0;
      send(1234, 0, Q_HI, "R10 bypass");
   endtask

   initial begin
      t_reset;
      t_mono_start;
      t_ramp_up;
      t_hold_band;
      t_idle;
      t_ramp_down;
      t_full_ramp;
      t_saturation;
      t_force;
      t_deemph;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule